// File: doc/BRIEF.md
# Synchronized Clock Stop Gating

This block sits between a clock synthesizer and the output drivers. It passes a fast processor clock, a bank of peripheral-bus clocks and one free-running copy of the bus clock. In the power-saving (mobile) configuration, two active-low stop requests can freeze the processor clock and the gated bus clocks. A stopped clock is held LOW. Every pulse that leaves the block has the full width of the source pulse.

The processor stop request is asynchronous. It is first captured on the rising edge of the free-running bus clock, then carried into the processor clock domain through a flop synchronizer. The bus-clock stop request is captured on the rising edge of the bus clock, and the gated bus clocks react one bus cycle later. In the desktop configuration both requests are ignored. Each enable is applied through a gate that follows its enable only while the source clock is LOW, so no pulse is ever cut short.

Top module: `clkstop_gate`

## Requirements
- R1: While `mobile_i` is 0, both stop inputs have no effect: `cpu_clk_o` and every bit of `pci_clk_o` follow their source clocks.
- R2: `cpu_stop_n_i` is sampled only on rising edges of `pcif_clk_i`. A LOW pulse that starts and ends between two such edges causes no missing `cpu_clk_o` pulse.
- R3: With `mobile_i` at 1, take the `pcif_clk_i` rising edge that first samples `cpu_stop_n_i` LOW. Exactly two further `cpu_clk_i` rising edges pass to `cpu_clk_o`, and the third is suppressed. After the edge that first samples it HIGH again, the first output pulse is the third `cpu_clk_i` rising edge. Both latencies fall inside the 2 to 4 cycle window.
- R4: `pci_stop_n_i` is sampled on rising edges of `pci_clk_i`. The pulse at the sampling edge keeps the old state. Starting with the next rising edge, all bits of `pci_clk_o` are stopped (value 0 = stop) or running (1 = run).
- R5: A stopped output is driven LOW for the whole time it is stopped.
- R6: `pcif_clk_o` follows `pcif_clk_i` regardless of either stop input or the mode.
- R7: Every output pulse rises with its source clock and lasts for the full HIGH phase of the source. An output is never HIGH while its source is LOW.
- R8: While `rst_n` is LOW, and after it is released with no stop requested, all gated clocks run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset, released per clock domain through synchronizers |
| cpu_clk_i | input | 1 | Internal processor clock |
| pci_clk_i | input | 1 | Internal bus clock for the gated bus outputs |
| pcif_clk_i | input | 1 | Free-running bus clock, also the sampling clock for the processor stop request |
| cpu_stop_n_i | input | 1 | Asynchronous processor clock stop request, active LOW |
| pci_stop_n_i | input | 1 | Bus clock stop request, active LOW |
| mobile_i | input | 1 | Latched configuration flag: 1 enables stop gating |
| cpu_clk_o | output | 1 | Gated processor clock |
| pci_clk_o | output | N_PCI | Gated bus clocks |
| pcif_clk_o | output | 1 | Free-running bus clock output |

## Verification
If an enable is stuck or sampled in the wrong domain, the pulse count changes. The error shows within the first processor or bus cycle counted after the sampling edge, as an extra or missing pulse, or as a restart at the wrong edge. If the gate updates while its clock is HIGH, an output pulse comes out shorter than the HIGH phase of its source, or the output goes HIGH while the source is LOW. The pulse-width and level monitors catch this in the same cycle. A synchronizer with the wrong depth moves the stop edge, and the exact count of two pulses after the sampling edge exposes it.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

  // Flop depth of the request synchronizer into the processor domain.
  localparam int unsigned SYNC_DEPTH = 2;

  // Run request: desktop configuration forces run, otherwise follow the
  // active-low stop input.
  function automatic logic run_req(input logic mobile, input logic stop_n);
    return (~mobile) | stop_n;
  endfunction

endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  generate
    if (STAGES == 1) begin : g_one
      assign stage_d = d;
    end else begin : g_many
      assign stage_d = {stage_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= {STAGES{RST_VAL}};
    end else begin
      stage_q <= stage_d;
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/clk_gate.sv
module clk_gate (
  input  logic clk_i,
  input  logic en_i,
  output logic clk_o
);

  logic en_l;

  // Enable follows only during the LOW phase, frozen while HIGH.
  always_latch begin
    if (!clk_i) begin
      en_l <= en_i;
    end
  end

  assign clk_o = clk_i & en_l;

endmodule

// File: rtl/clkstop_gate.sv
module clkstop_gate
  import clkstop_pkg::*;
#(
  parameter int unsigned N_PCI       = 5,
  parameter int unsigned SYNC_STAGES = SYNC_DEPTH
) (
  input  logic             rst_n,
  input  logic             cpu_clk_i,
  input  logic             pci_clk_i,
  input  logic             pcif_clk_i,
  input  logic             cpu_stop_n_i,
  input  logic             pci_stop_n_i,
  input  logic             mobile_i,
  output logic             cpu_clk_o,
  output logic [N_PCI-1:0] pci_clk_o,
  output logic             pcif_clk_o
);

  localparam int unsigned RST_STAGES = 2;

  // Per-domain reset release
  logic cpu_rst_n;
  logic pci_rst_n;
  logic pcif_rst_n;

  bit_sync #(.STAGES(RST_STAGES), .RST_VAL(1'b0)) u_rst_cpu (
    .clk(cpu_clk_i), .rst_n(rst_n), .d(1'b1), .q(cpu_rst_n));
  bit_sync #(.STAGES(RST_STAGES), .RST_VAL(1'b0)) u_rst_pci (
    .clk(pci_clk_i), .rst_n(rst_n), .d(1'b1), .q(pci_rst_n));
  bit_sync #(.STAGES(RST_STAGES), .RST_VAL(1'b0)) u_rst_pcif (
    .clk(pcif_clk_i), .rst_n(rst_n), .d(1'b1), .q(pcif_rst_n));

  // Processor stop request: capture on the free-running bus clock
  logic cpu_run_d;
  logic cpu_run_f;
  logic cpu_en;

  always_comb begin
    cpu_run_d = run_req(mobile_i, cpu_stop_n_i);
  end

  always_ff @(posedge pcif_clk_i or negedge pcif_rst_n) begin
    if (!pcif_rst_n) begin
      cpu_run_f <= 1'b1;
    end else begin
      cpu_run_f <= cpu_run_d;
    end
  end

  bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cpu_sync (
    .clk(cpu_clk_i), .rst_n(cpu_rst_n), .d(cpu_run_f), .q(cpu_en));

  // Bus stop request: capture on the bus clock itself
  logic pci_run_d;
  logic pci_en;

  always_comb begin
    pci_run_d = run_req(mobile_i, pci_stop_n_i);
  end

  always_ff @(posedge pci_clk_i or negedge pci_rst_n) begin
    if (!pci_rst_n) begin
      pci_en <= 1'b1;
    end else begin
      pci_en <= pci_run_d;
    end
  end

  // Output gates
  clk_gate u_cpu_gate (.clk_i(cpu_clk_i), .en_i(cpu_en), .clk_o(cpu_clk_o));

  generate
    for (genvar gi = 0; gi < N_PCI; gi++) begin : g_pci
      clk_gate u_pci_gate (.clk_i(pci_clk_i), .en_i(pci_en), .clk_o(pci_clk_o[gi]));
    end
  endgenerate

  // Same gate cell with the enable tied high keeps the free-running copy
  // matched in delay to the gated bus clocks.
  clk_gate u_pcif_gate (.clk_i(pcif_clk_i), .en_i(1'b1), .clk_o(pcif_clk_o));

endmodule

// File: rtl/clkstop_gate_chk.sv
module clkstop_gate_chk #(
  parameter int unsigned N_PCI = 5
) (
  input logic             cpu_clk_i,
  input logic             pci_clk_i,
  input logic             pcif_clk_i,
  input logic             pci_stop_n_i,
  input logic             mobile_i,
  input logic             cpu_rst_n,
  input logic             pci_rst_n,
  input logic             pcif_rst_n,
  input logic             cpu_run_f,
  input logic             cpu_en,
  input logic             pci_en,
  input logic             cpu_clk_o,
  input logic [N_PCI-1:0] pci_clk_o,
  input logic             pcif_clk_o
);

  // R1: desktop configuration forces the captured processor request to run
  p_cpu_desktop_r1: assert property (@(posedge pcif_clk_i) disable iff (!pcif_rst_n)
    !mobile_i |=> cpu_run_f);

  // R1: desktop configuration forces the bus enable to run
  p_pci_desktop_r1: assert property (@(posedge pci_clk_i) disable iff (!pci_rst_n)
    !mobile_i |=> pci_en);

  // R4: a sampled bus stop request clears the enable at that edge
  p_pci_stop_r4: assert property (@(posedge pci_clk_i) disable iff (!pci_rst_n)
    (mobile_i && !pci_stop_n_i) |=> !pci_en);

  // R3: processor enable falls only two edges after a captured stop
  p_cpu_fall_r3: assert property (@(posedge cpu_clk_i) disable iff (!cpu_rst_n)
    $fell(cpu_en) |-> !$past(cpu_run_f, 2));

  // R3: processor enable rises only two edges after a captured run
  p_cpu_rise_r3: assert property (@(posedge cpu_clk_i) disable iff (!cpu_rst_n)
    $rose(cpu_en) |-> $past(cpu_run_f, 2));

  // R5, R7: HIGH phase output equals the enable held over the prior LOW phase
  p_cpu_shape_r7: assert property (@(negedge cpu_clk_i) disable iff (!cpu_rst_n)
    cpu_clk_o == $past(cpu_en));

  // R5, R7: same for every gated bus clock
  p_pci_shape_r5: assert property (@(negedge pci_clk_i) disable iff (!pci_rst_n)
    pci_clk_o == {N_PCI{$past(pci_en)}});

  // R6: free-running output is HIGH through every source HIGH phase
  p_pcif_run_r6: assert property (@(negedge pcif_clk_i) disable iff (!pcif_rst_n)
    pcif_clk_o);

endmodule

bind clkstop_gate clkstop_gate_chk #(.N_PCI(N_PCI)) u_chk (
  .cpu_clk_i    (cpu_clk_i),
  .pci_clk_i    (pci_clk_i),
  .pcif_clk_i   (pcif_clk_i),
  .pci_stop_n_i (pci_stop_n_i),
  .mobile_i     (mobile_i),
  .cpu_rst_n    (cpu_rst_n),
  .pci_rst_n    (pci_rst_n),
  .pcif_rst_n   (pcif_rst_n),
  .cpu_run_f    (cpu_run_f),
  .cpu_en       (cpu_en),
  .pci_en       (pci_en),
  .cpu_clk_o    (cpu_clk_o),
  .pci_clk_o    (pci_clk_o),
  .pcif_clk_o   (pcif_clk_o)
);

// File: tb/sim_clkstop_gate.sv
module sim_clkstop_gate;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int N_PCI = 5;

  logic             rst_n;
  logic             cpu_clk;
  logic             pci_clk;
  logic             pcif_clk;
  logic             cpu_stop_n;
  logic             pci_stop_n;
  logic             mobile;
  logic             cpu_clk_o;
  logic [N_PCI-1:0] pci_clk_o;
  logic             pcif_clk_o;

  clkstop_gate #(.N_PCI(N_PCI)) u0 (
    .rst_n        (rst_n),
    .cpu_clk_i    (cpu_clk),
    .pci_clk_i    (pci_clk),
    .pcif_clk_i   (pcif_clk),
    .cpu_stop_n_i (cpu_stop_n),
    .pci_stop_n_i (pci_stop_n),
    .mobile_i     (mobile),
    .cpu_clk_o    (cpu_clk_o),
    .pci_clk_o    (pci_clk_o),
    .pcif_clk_o   (pcif_clk_o)
  );

  // 125 MHz processor clock, rises at 4 + 8k ns
  initial begin
    cpu_clk = 1'b0;
    forever #4 cpu_clk = ~cpu_clk;
  end

  // Bus clocks, 32 ns period, rising at 6 + 32k ns (off the processor edges)
  initial begin
    pci_clk  = 1'b0;
    pcif_clk = 1'b0;
    #6;
    forever begin
      pci_clk = 1'b1; pcif_clk = 1'b1;
      #16;
      pci_clk = 1'b0; pcif_clk = 1'b0;
      #16;
    end
  end

  // Scoreboard
  typedef struct {
    string tag;
    int    val;
  } exp_t;

  exp_t exp_q[$];
  int   act_q[$];
  event act_ev;
  int   n_checks = 0;
  int   n_fails  = 0;
  bit   done     = 1'b0;

  function automatic void drain();
    while (exp_q.size() > 0 && act_q.size() > 0) begin
      exp_t e;
      int   a;
      e = exp_q.pop_front();
      a = act_q.pop_front();
      n_checks++;
      if (a != e.val) begin
        n_fails++;
        $display("FAIL %s actual=%0d expected=%0d", e.tag, a, e.val);
      end
    end
  endfunction

  initial begin
    forever begin
      @(act_ev);
      drain();
    end
  end

  task automatic expect_val(input string tag, input int val);
    exp_t e;
    e.tag = tag;
    e.val = val;
    exp_q.push_back(e);
  endtask

  task automatic observe(input int val);
    act_q.push_back(val);
    -> act_ev;
  endtask

  // Measurement helpers, sampling 1 ns after each source rising edge
  task automatic count_cpu(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge cpu_clk);
      #1;
      if (cpu_clk_o) c++;
    end
  endtask

  // Result = 100 * (edges with all bits HIGH) + (edges with all bits LOW)
  task automatic count_pci(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge pci_clk);
      #1;
      if (pci_clk_o == {N_PCI{1'b1}}) c += 100;
      else if (pci_clk_o == '0) c += 1;
    end
  endtask

  task automatic count_pcif(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge pcif_clk);
      #1;
      if (pcif_clk_o) c++;
    end
  endtask

  // Pulse-shape monitor for the processor output (R7)
  int    bad_shape = 0;
  realtime t_rise  = 0.0;

  initial begin
    forever begin
      @(posedge cpu_clk_o);
      t_rise = $realtime;
      if (!cpu_clk && rst_n) bad_shape++;
    end
  end

  initial begin
    forever begin
      @(negedge cpu_clk_o);
      if (rst_n && ($realtime - t_rise) != 4.0) bad_shape++;
    end
  end

  // Watchdog
  task automatic finish_run();
    drain();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end

  // Stimulus
  initial begin
    int c;
    rst_n      = 1'b0;
    mobile     = 1'b1;
    cpu_stop_n = 1'b1;
    pci_stop_n = 1'b1;

    repeat (6) @(posedge pci_clk);
    // R8: clocks run while reset is held
    expect_val("R8 cpu pulses during reset", 8);
    count_cpu(8, c); observe(c);

    @(negedge pci_clk);
    rst_n = 1'b1;
    repeat (4) @(posedge pci_clk);
    expect_val("R8 cpu pulses after reset", 8);
    count_cpu(8, c); observe(c);
    expect_val("R8 pci all running after reset", 400);
    count_pci(4, c); observe(c);

    // R3: processor stop, exactly two pulses after the sampling edge
    @(negedge pcif_clk);
    cpu_stop_n = 1'b0;
    @(posedge pcif_clk);
    expect_val("R3 cpu pulses after stop sample", 2);
    count_cpu(8, c); observe(c);
    // R5: stays LOW while stopped
    expect_val("R5 cpu held low", 0);
    count_cpu(8, c); observe(c);
    expect_val("R6 free-running during cpu stop", 4);
    count_pcif(4, c); observe(c);

    // R3: restart, first pulse at third edge
    @(negedge pcif_clk);
    cpu_stop_n = 1'b1;
    @(posedge pcif_clk);
    expect_val("R3 cpu pulses after run sample", 6);
    count_cpu(8, c); observe(c);

    // R4: bus stop, one cycle later
    @(negedge pci_clk);
    pci_stop_n = 1'b0;
    @(posedge pci_clk);
    #1;
    expect_val("R4 pci old state at sampling edge", 100);
    observe((pci_clk_o == {N_PCI{1'b1}}) ? 100 : ((pci_clk_o == '0) ? 1 : 0));
    expect_val("R4 R5 pci stopped low", 4);
    count_pci(4, c); observe(c);
    expect_val("R6 free-running during pci stop", 4);
    count_pcif(4, c); observe(c);
    expect_val("R4 cpu unaffected by pci stop", 8);
    count_cpu(8, c); observe(c);

    // R4: bus restart
    @(negedge pci_clk);
    pci_stop_n = 1'b1;
    @(posedge pci_clk);
    #1;
    expect_val("R4 pci still stopped at sampling edge", 1);
    observe((pci_clk_o == {N_PCI{1'b1}}) ? 100 : ((pci_clk_o == '0) ? 1 : 0));
    expect_val("R4 pci running after restart", 400);
    count_pci(4, c); observe(c);

    // R2: short request between sampling edges is not seen
    @(posedge pcif_clk);
    #4 cpu_stop_n = 1'b0;
    #4 cpu_stop_n = 1'b1;
    @(posedge pcif_clk);
    expect_val("R2 short cpu request ignored", 8);
    count_cpu(8, c); observe(c);

    // R1: desktop configuration ignores both stops
    mobile     = 1'b0;
    cpu_stop_n = 1'b0;
    pci_stop_n = 1'b0;
    repeat (4) @(posedge pci_clk);
    expect_val("R1 cpu runs in desktop", 8);
    count_cpu(8, c); observe(c);
    expect_val("R1 pci runs in desktop", 400);
    count_pci(4, c); observe(c);

    // Back to mobile with stops held: both stop
    mobile = 1'b1;
    repeat (4) @(posedge pci_clk);
    expect_val("R5 cpu low after mobile entry", 0);
    count_cpu(8, c); observe(c);
    expect_val("R5 pci low after mobile entry", 4);
    count_pci(4, c); observe(c);
    expect_val("R6 free-running with both stopped", 4);
    count_pcif(4, c); observe(c);

    cpu_stop_n = 1'b1;
    pci_stop_n = 1'b1;
    repeat (4) @(posedge pci_clk);

    expect_val("R7 truncated or misplaced cpu pulses", 0);
    observe(bad_shape);

    done = 1'b1;
    #1;
    finish_run();
  end

endmodule